// File: doc/BRIEF.md
# Single-Buffer USB IN Endpoint Handshake Controller

This block runs the device side of one USB IN endpoint backed by a single packet buffer. Firmware fills the buffer through a byte write port and then hands it to hardware by raising a ready flag. While the ready flag is clear, every IN token is refused with a NAK. Once the flag is set, the next IN token makes the block stream the stored payload to a packet engine, one byte per cycle. The block then waits for the host handshake.

An ACK returns the buffer to firmware. It also latches a completion flag, which can drive an interrupt until firmware clears it. If no ACK comes within a fixed window, the buffer stays with hardware and the same payload goes out again on the next IN token. The packet engine sees an abstract interface: a token strobe, an ACK strobe, a NAK strobe, a packet-start strobe with a length, and a byte stream.

Top module: `usb_in_ep`

## Requirements
- R1: After reset, `st_rdy`, `st_cmpl`, `st_ovr`, `st_ie`, `irq`, `rsp_nak`, `pkt_start` and `tx_valid` are 0, and `st_cnt` is 0.
- R2: A `tok_in` pulse while the handshake engine is idle and `st_rdy` is 0 makes `rsp_nak` high for exactly the one cycle after the token edge. `pkt_start` and `tx_valid` stay low.
- R3: A `tok_in` pulse while idle with `st_rdy` at 1 makes `pkt_start` high for the one cycle after the token edge. For a non-zero length, the payload bytes appear on `tx_data` with `tx_valid` high on consecutive cycles, starting in that same cycle, in the order they were written. `tx_last` is high only on the final byte.
- R4: An `hs_ack` pulse while the block waits for a handshake clears `st_rdy`, sets `st_cmpl` and returns `st_cnt` to 0 at the same edge.
- R5: `st_cmpl` stays set until an `fw_clr_cmpl` pulse. If an ACK and a clear fall on the same edge, the flag stays set.
- R6: A `fifo_we` write while `st_rdy` is 1, or while `DEPTH` bytes are already stored, leaves `st_cnt` and the buffer unchanged. It sets `st_ovr`, which stays set until an `fw_clr_err` pulse.
- R7: If no `hs_ack` arrives within `TIMEOUT` cycles after the last byte, the block goes idle with `st_rdy` still 1. The next token resends the same payload.
- R8: `fw_set_rdy` latches the number of bytes written (`st_cnt`) into `pkt_len`. With a count of 0, a token gives a `pkt_start` with `pkt_len` 0 and no `tx_valid`, and the ACK wait follows as usual.
- R9: `irq` is high exactly when `st_cmpl` and `st_ie` are both 1. `st_ie` takes the value of `fw_ie_d` on each `fw_ie_we` pulse.
- R10: A `tok_in` during transmission or during the handshake wait gives neither `rsp_nak` nor `pkt_start`. An `hs_ack` outside the handshake wait changes no flag.
- R11: `fw_set_rdy` while `st_rdy` is already 1 leaves `pkt_len` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_set_rdy | input | 1 | Firmware pulse: hand the buffer to hardware |
| fw_clr_cmpl | input | 1 | Firmware pulse: clear the completion flag |
| fw_clr_err | input | 1 | Firmware pulse: clear the overrun flag |
| fw_ie_we | input | 1 | Firmware write strobe for the interrupt enable |
| fw_ie_d | input | 1 | Interrupt enable value |
| fifo_we | input | 1 | Buffer byte write strobe |
| fifo_wdata | input | DW | Buffer write byte |
| st_rdy | output | 1 | Buffer is owned by hardware |
| st_cmpl | output | 1 | Completion flag, interrupt pending |
| st_ovr | output | 1 | Sticky overrun error |
| st_ie | output | 1 | Interrupt enable |
| st_cnt | output | CW | Bytes currently loaded |
| irq | output | 1 | Interrupt request |
| tok_in | input | 1 | IN token strobe from the packet engine |
| hs_ack | input | 1 | Host ACK strobe |
| rsp_nak | output | 1 | Answer the token with NAK |
| pkt_start | output | 1 | Data packet begins |
| pkt_len | output | CW | Latched payload length |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | DW | Payload byte |
| tx_last | output | 1 | Final payload byte |

## Verification
The properties assume that `tok_in`, `hs_ack` and the firmware command inputs are single-cycle strobes. They also assume that reset is held for at least two cycles, so that `$past` sees settled flags. The bench drives every strobe for exactly one clock and never writes the buffer in the same cycle as `fw_set_rdy`; the count latched at that edge is defined only under that condition. The bench sends tokens only with at least one idle cycle between packet phases, except in the test that deliberately injects a token mid-handshake.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic set_rdy;
        logic clr_cmpl;
        logic ie_we;
        logic ie_d;
    } fw_cmd_t;

    // True when the byte at index ptr is the last one of a len-byte packet.
    function automatic logic final_beat(input int unsigned ptr, input int unsigned len);
        return (ptr + 1) == len;
    endfunction

endpackage

// File: rtl/ep_payload_buf.sv
module ep_payload_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          clr_err,
    input  logic          locked,
    input  logic          rewind,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] wr_cnt,
    output logic          ovr
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          accept;

    assign accept  = we && !locked && (wr_cnt != FULL);
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_cnt[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt <= '0;
            ovr    <= 1'b0;
        end else begin
            if (rewind)      wr_cnt <= '0;
            else if (accept) wr_cnt <= wr_cnt + 1'b1;

            if (we && !accept) ovr <= 1'b1;
            else if (clr_err)  ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/ep_flags.sv
module ep_flags
    import usb_in_ep_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  fw_cmd_t       cmd,
    input  logic          ack_evt,
    input  logic [CW-1:0] wr_cnt,
    output logic          rdy,
    output logic          cmpl,
    output logic          ie,
    output logic [CW-1:0] len_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy   <= 1'b0;
            cmpl  <= 1'b0;
            ie    <= 1'b0;
            len_q <= '0;
        end else begin
            if (ack_evt) begin
                rdy <= 1'b0;
            end else if (cmd.set_rdy && !rdy) begin
                rdy   <= 1'b1;
                len_q <= wr_cnt;
            end

            if (ack_evt)           cmpl <= 1'b1;
            else if (cmd.clr_cmpl) cmpl <= 1'b0;

            if (cmd.ie_we) ie <= cmd.ie_d;
        end
    end

    assign irq = cmpl & ie;
endmodule

// File: rtl/ep_tx_fsm.sv
module ep_tx_fsm
    import usb_in_ep_pkg::*;
#(
    parameter int CW      = 7,
    parameter int TIMEOUT = 32,
    parameter int TW      = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_in,
    input  logic          hs_ack,
    input  logic          rdy,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] rd_ptr,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          rsp_nak,
    output logic          pkt_start,
    output logic          ack_evt
);
    localparam logic [TW-1:0] T_END = TW'(TIMEOUT - 1);

    tx_state_e     state;
    logic [TW-1:0] timer;
    logic          last_hit;

    assign last_hit = final_beat(32'(rd_ptr), 32'(len));
    assign tx_valid = (state == TX_SEND);
    assign tx_last  = tx_valid && last_hit;
    assign ack_evt  = (state == TX_WAIT) && hs_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            rd_ptr    <= '0;
            timer     <= '0;
            rsp_nak   <= 1'b0;
            pkt_start <= 1'b0;
        end else begin
            rsp_nak   <= 1'b0;
            pkt_start <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (tok_in) begin
                        if (rdy) begin
                            pkt_start <= 1'b1;
                            rd_ptr    <= '0;
                            timer     <= '0;
                            state     <= (len == '0) ? TX_WAIT : TX_SEND;
                        end else begin
                            rsp_nak <= 1'b1;
                        end
                    end
                end
                TX_SEND: begin
                    rd_ptr <= rd_ptr + 1'b1;
                    if (last_hit) begin
                        state <= TX_WAIT;
                        timer <= '0;
                    end
                end
                TX_WAIT: begin
                    if (hs_ack)              state <= TX_IDLE;
                    else if (timer == T_END) state <= TX_IDLE;
                    else                     timer <= timer + 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_in_ep.sv
module usb_in_ep
    import usb_in_ep_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 64,
    parameter int TIMEOUT = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_set_rdy,
    input  logic          fw_clr_cmpl,
    input  logic          fw_clr_err,
    input  logic          fw_ie_we,
    input  logic          fw_ie_d,
    input  logic          fifo_we,
    input  logic [DW-1:0] fifo_wdata,
    output logic          st_rdy,
    output logic          st_cmpl,
    output logic          st_ovr,
    output logic          st_ie,
    output logic [CW-1:0] st_cnt,
    output logic          irq,
    input  logic          tok_in,
    input  logic          hs_ack,
    output logic          rsp_nak,
    output logic          pkt_start,
    output logic [CW-1:0] pkt_len,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last
);
    fw_cmd_t       cmd;
    logic          ack_evt;
    logic [CW-1:0] rd_ptr;

    assign cmd = '{set_rdy: fw_set_rdy, clr_cmpl: fw_clr_cmpl,
                   ie_we: fw_ie_we, ie_d: fw_ie_d};

    ep_payload_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .we      (fifo_we),
        .wdata   (fifo_wdata),
        .clr_err (fw_clr_err),
        .locked  (st_rdy),
        .rewind  (ack_evt),
        .rd_idx  (rd_ptr[AW-1:0]),
        .rd_data (tx_data),
        .wr_cnt  (st_cnt),
        .ovr     (st_ovr)
    );

    ep_flags #(.CW(CW)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ack_evt (ack_evt),
        .wr_cnt  (st_cnt),
        .rdy     (st_rdy),
        .cmpl    (st_cmpl),
        .ie      (st_ie),
        .len_q   (pkt_len),
        .irq     (irq)
    );

    ep_tx_fsm #(.CW(CW), .TIMEOUT(TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tok_in    (tok_in),
        .hs_ack    (hs_ack),
        .rdy       (st_rdy),
        .len       (pkt_len),
        .rd_ptr    (rd_ptr),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .rsp_nak   (rsp_nak),
        .pkt_start (pkt_start),
        .ack_evt   (ack_evt)
    );
endmodule

// File: rtl/usb_in_ep_chk.sv
module usb_in_ep_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          fw_clr_cmpl,
    input logic          fw_clr_err,
    input logic          tok_in,
    input logic          st_rdy,
    input logic          st_cmpl,
    input logic          st_ovr,
    input logic          st_ie,
    input logic [CW-1:0] st_cnt,
    input logic          irq,
    input logic          rsp_nak,
    input logic          pkt_start,
    input logic [CW-1:0] pkt_len,
    input logic          tx_valid
);
    AST_NAK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rsp_nak |-> ($past(tok_in) && !$past(st_rdy)));                   // R2
    AST_NAK_XOR_DATA: assert property (@(posedge clk) disable iff (rst)
        !(rsp_nak && pkt_start));                                         // R2
    AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> ($past(tok_in) && $past(st_rdy)));                  // R3
    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (rst)
        $fell(st_rdy) |-> (st_cmpl && st_cnt == '0));                     // R4
    AST_CMPL_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_cmpl && !fw_clr_cmpl) |=> st_cmpl);                           // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_ovr && !fw_clr_err) |=> st_ovr);                              // R6
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st_rdy && $past(st_rdy)) |-> $stable(st_cnt));                   // R6
    AST_NO_BYTES_ZLP: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (pkt_len != '0));                                    // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_cmpl && st_ie));                                      // R9
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_rdy && $past(st_rdy)) |-> $stable(pkt_len));                  // R11
endmodule

bind usb_in_ep usb_in_ep_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fw_clr_cmpl (fw_clr_cmpl),
    .fw_clr_err  (fw_clr_err),
    .tok_in      (tok_in),
    .st_rdy      (st_rdy),
    .st_cmpl     (st_cmpl),
    .st_ovr      (st_ovr),
    .st_ie       (st_ie),
    .st_cnt      (st_cnt),
    .irq         (irq),
    .rsp_nak     (rsp_nak),
    .pkt_start   (pkt_start),
    .pkt_len     (pkt_len),
    .tx_valid    (tx_valid)
);

// File: tb/tb_usb_in_ep.sv
module tb_usb_in_ep;
    localparam int DW      = 8;
    localparam int DEPTH   = 64;
    localparam int TIMEOUT = 32;
    localparam int CW      = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fw_set_rdy = 0, fw_clr_cmpl = 0, fw_clr_err = 0;
    logic          fw_ie_we = 0, fw_ie_d = 0;
    logic          fifo_we = 0;
    logic [DW-1:0] fifo_wdata = '0;
    logic          tok_in = 0, hs_ack = 0;
    logic          st_rdy, st_cmpl, st_ovr, st_ie, irq;
    logic [CW-1:0] st_cnt, pkt_len;
    logic          rsp_nak, pkt_start, tx_valid, tx_last;
    logic [DW-1:0] tx_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    usb_in_ep #(.DW(DW), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 8'hFF);
    endfunction

    task automatic load(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            fifo_we = 1; fifo_wdata = pat(seed, i);
            tick();
        end
        fifo_we = 0;
    endtask

    task automatic pulse_rdy();  fw_set_rdy = 1;  tick(); fw_set_rdy = 0;  endtask
    task automatic pulse_tok();  tok_in = 1;      tick(); tok_in = 0;      endtask
    task automatic pulse_ack();  hs_ack = 1;      tick(); hs_ack = 0;      endtask
    task automatic pulse_clr();  fw_clr_cmpl = 1; tick(); fw_clr_cmpl = 0; endtask

    // Issue a token with the buffer ready and check the streamed packet.
    task automatic expect_packet(input string req, input int seed, input int n);
        pulse_tok();
        chk({req, " pkt_start"}, pkt_start, 1);
        chk({req, " pkt_len"}, pkt_len, n);
        chk({req, " no nak"}, rsp_nak, 0);
        for (int i = 0; i < n; i++) begin
            chk({req, " tx_valid"}, tx_valid, 1);
            chk({req, " tx_data"}, tx_data, pat(seed, i));
            chk({req, " tx_last"}, tx_last, (i == n - 1) ? 1 : 0);
            tick();
        end
        chk({req, " stream ended"}, tx_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 rdy", st_rdy, 0);   chk("R1 cmpl", st_cmpl, 0);
        chk("R1 ovr", st_ovr, 0);   chk("R1 ie", st_ie, 0);
        chk("R1 cnt", st_cnt, 0);   chk("R1 irq", irq, 0);
        chk("R1 nak", rsp_nak, 0);  chk("R1 start", pkt_start, 0);
        chk("R1 valid", tx_valid, 0);
    endtask

    task automatic t_nak_empty();
        pulse_tok();
        chk("R2 nak", rsp_nak, 1);
        chk("R2 no start", pkt_start, 0);
        chk("R2 no data", tx_valid, 0);
        tick();
        chk("R2 nak one cycle", rsp_nak, 0);
    endtask

    task automatic t_send_ack(input int seed, input int n);
        load(seed, n);
        chk("R8 count", st_cnt, n);
        pulse_rdy();
        chk("R8 len latched", pkt_len, n);
        chk("R3 rdy set", st_rdy, 1);
        expect_packet("R3", seed, n);
        pulse_ack();
        chk("R4 rdy cleared", st_rdy, 0);
        chk("R4 cmpl set", st_cmpl, 1);
        chk("R4 cnt rewound", st_cnt, 0);
        tick();
        chk("R5 cmpl held", st_cmpl, 1);
        pulse_clr();
        chk("R5 cmpl cleared", st_cmpl, 0);
    endtask

    task automatic t_zlp();
        pulse_rdy();
        chk("R8 zlp len", pkt_len, 0);
        pulse_tok();
        chk("R8 zlp start", pkt_start, 1);
        chk("R8 zlp no data", tx_valid, 0);
        tick();
        chk("R8 zlp waits", st_rdy, 1);
        pulse_ack();
        chk("R8 zlp completes", st_cmpl, 1);
        pulse_clr();
    endtask

    task automatic t_overrun();
        load(3, 4);
        pulse_rdy();
        fifo_we = 1; fifo_wdata = 8'hEE; tick(); fifo_we = 0;
        chk("R6 cnt unchanged", st_cnt, 4);
        chk("R6 ovr set", st_ovr, 1);
        fw_set_rdy = 1; tick(); fw_set_rdy = 0;
        chk("R11 len unchanged", pkt_len, 4);
        expect_packet("R6 payload intact", 3, 4);
        pulse_ack();
        tick();
        chk("R6 ovr sticky", st_ovr, 1);
        fw_clr_err = 1; tick(); fw_clr_err = 0;
        chk("R6 ovr cleared", st_ovr, 0);
        pulse_clr();
    endtask

    task automatic t_full();
        load(4, DEPTH);
        chk("R6 full count", st_cnt, DEPTH);
        chk("R6 no ovr yet", st_ovr, 0);
        load(9, 1);
        chk("R6 full ignored", st_cnt, DEPTH);
        chk("R6 full ovr", st_ovr, 1);
        pulse_rdy();
        expect_packet("R6 full payload", 4, DEPTH);
        pulse_ack();
        fw_clr_err = 1; tick(); fw_clr_err = 0;
        pulse_clr();
    endtask

    task automatic t_timeout_resend();
        load(5, 3);
        pulse_rdy();
        expect_packet("R7 first", 5, 3);
        pulse_tok();
        chk("R10 token in wait no start", pkt_start, 0);
        chk("R10 token in wait no nak", rsp_nak, 0);
        for (int i = 0; i < TIMEOUT + 2; i++) tick();
        chk("R7 rdy kept", st_rdy, 1);
        chk("R7 no cmpl", st_cmpl, 0);
        expect_packet("R7 resend", 5, 3);
        pulse_ack();
        chk("R7 done", st_cmpl, 1);
        pulse_clr();
    endtask

    task automatic t_ignored_ack();
        load(6, 2);
        pulse_ack();
        chk("R10 idle ack cmpl", st_cmpl, 0);
        chk("R10 idle ack cnt", st_cnt, 2);
        pulse_rdy();
        pulse_ack();
        chk("R10 idle ack rdy", st_rdy, 1);
        expect_packet("R10 after", 6, 2);
        pulse_ack();
        pulse_clr();
    endtask

    task automatic t_irq();
        fw_ie_we = 1; fw_ie_d = 1; tick(); fw_ie_we = 0;
        chk("R9 ie", st_ie, 1);
        chk("R9 irq idle", irq, 0);
        load(7, 1);
        pulse_rdy();
        expect_packet("R9 pkt", 7, 1);
        hs_ack = 1; fw_clr_cmpl = 1; tick(); hs_ack = 0; fw_clr_cmpl = 0;
        chk("R5 set wins", st_cmpl, 1);
        chk("R9 irq on", irq, 1);
        fw_ie_we = 1; fw_ie_d = 0; tick(); fw_ie_we = 0;
        chk("R9 irq masked", irq, 0);
        chk("R9 cmpl kept", st_cmpl, 1);
        pulse_clr();
        chk("R9 irq off", irq, 0);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) tick();
        rst = 0;
        tick();
        t_reset();
        t_nak_empty();
        t_send_ack(1, 5);
        t_send_ack(2, 1);
        t_zlp();
        t_overrun();
        t_full();
        t_timeout_resend();
        t_ignored_ack();
        t_irq();
        t_nak_empty();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule